// File: doc/BRIEF.md
# Shared Data RAM with CPU-Priority Dual Access

This block is a two-port data RAM that a processor and a DMA engine share. Each port can read or write in any cycle. Neither port has a wait signal, so neither port can hold up the other. The RAM occupies a fixed window at the top of a 16-bit byte address map. Each port decodes its own address against that window. An access that falls outside the window is ignored, and a read outside the window returns zero. When the DMA engine is idle, the CPU port works as plain general-purpose storage.

Both ports carry 16-bit words and two byte enables. Address bit 0 is ignored. When both ports write the same byte of the same word in the same cycle, the CPU byte is kept and the DMA byte is dropped. The DMA side then sees a single-cycle collision pulse. Each port's read data is registered. A read returns the word as it stood before any write made in the same cycle.

The block has no control state machine. All behaviour is decided per cycle in the address decoders and the per-lane storage.

Top module: `dpram_cpu_prio`

## Requirements
- R1: An access hits the RAM only when BASE_ADDR <= addr < BASE_ADDR + 2*DEPTH (default window 0xF800 to 0xFFFF). The word index is (addr - BASE_ADDR) >> 1.
- R2: A CPU write stores the data bytes whose enables are set (be[0] selects bits 7:0 and be[1] selects bits 15:8). A read presents its data on rdata one clock after the request.
- R3: When both ports write the same word in the same cycle with an overlapping byte enable, the CPU bytes are stored in every overlapping lane.
- R4: Same-cycle writes by both ports to different byte lanes of the same word both take effect, and no collision is flagged.
- R5: dma_coll is high for exactly the cycle after a cycle in which a DMA write byte was discarded under R3. It is low at all other times.
- R6: Out-of-window reads return zero. Out-of-window writes change no RAM location, including the location their low address bits alias to.
- R7: A read on one port in the same cycle as a write to that word on the other port returns the old contents.
- R8: Both ports complete independent accesses to any locations in the same cycle, with no stall.
- R9: After reset, both rdata outputs and dma_coll are zero. An rdata output holds its value in every cycle in which its port issues no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_en | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_be | input | 2 | CPU byte enables |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU registered read data |
| dma_en | input | 1 | DMA access request |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_be | input | 2 | DMA byte enables |
| dma_addr | input | 16 | DMA byte address |
| dma_wdata | input | 16 | DMA write data |
| dma_rdata | output | 16 | DMA registered read data |
| dma_coll | output | 1 | One-cycle pulse: DMA write byte discarded |

## Verification
The hardest case to reach from the ports is a same-lane, same-word write collision. With uniform random addresses over a 1024-word window, both ports almost never land on one word in the same cycle. The random stimulus therefore sends most accesses to a hot set of eight words and draws random byte enables. This produces full-word collisions, partial collisions and disjoint-lane writes to one word. Directed cycles add an exact collision, a disjoint-lane write pair, a read that meets a write, and an out-of-window write that aliases to word zero.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = 2;
    localparam int unsigned DATA_W = LANE_W * LANES;
    localparam int unsigned ADDR_W = 16;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/dpram_win_dec.sv
module dpram_win_dec #(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned BASE       = 16'hF800,
    parameter int unsigned SIZE_BYTES = 2048,
    parameter int unsigned IDX_W      = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W:0]   LO_L   = (ADDR_W+1)'(BASE);
    localparam logic [ADDR_W:0]   HI_L   = (ADDR_W+1)'(BASE + SIZE_BYTES);
    localparam logic [ADDR_W-1:0] BASE_L = ADDR_W'(BASE);

    logic [ADDR_W:0] wide_addr;

    always_comb begin
        wide_addr = {1'b0, addr};
        hit       = (wide_addr >= LO_L) && (wide_addr < HI_L);
        idx       = IDX_W'((addr - BASE_L) >> 1);
    end
endmodule

// File: rtl/dpram_lane_bank.sv
module dpram_lane_bank #(
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic [LANE_W-1:0] cpu_d,
    input  logic              dma_wr,
    input  logic [IDX_W-1:0]  dma_idx,
    input  logic [LANE_W-1:0] dma_d,
    output logic [LANE_W-1:0] cpu_q,
    output logic [LANE_W-1:0] dma_q,
    output logic              lane_coll
);
    logic [LANE_W-1:0] mem [DEPTH];
    logic              dma_keep;

    always_comb begin
        lane_coll = cpu_wr && dma_wr && (cpu_idx == dma_idx);
        dma_keep  = dma_wr && !lane_coll;
        cpu_q     = mem[cpu_idx];
        dma_q     = mem[dma_idx];
    end

    always_ff @(posedge clk) begin
        if (dma_keep) mem[dma_idx] <= dma_d;
        if (cpu_wr)   mem[cpu_idx] <= cpu_d;
    end

    AST_CPU_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && dma_wr && (cpu_idx == dma_idx)) |=> (mem[$past(cpu_idx)] == $past(cpu_d))); // R3
endmodule

// File: rtl/dpram_cpu_prio.sv
module dpram_cpu_prio #(
    parameter int unsigned BASE_ADDR = 16'hF800,
    parameter int unsigned DEPTH     = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_en,
    input  logic        cpu_we,
    input  logic [1:0]  cpu_be,
    input  logic [15:0] cpu_addr,
    input  logic [15:0] cpu_wdata,
    output logic [15:0] cpu_rdata,
    input  logic        dma_en,
    input  logic        dma_we,
    input  logic [1:0]  dma_be,
    input  logic [15:0] dma_addr,
    input  logic [15:0] dma_wdata,
    output logic [15:0] dma_rdata,
    output logic        dma_coll
);
    import dpram_pkg::*;

    localparam int unsigned IDX_W      = $clog2(DEPTH);
    localparam int unsigned SIZE_BYTES = DEPTH * LANES;

    logic             cpu_hit, dma_hit;
    logic [IDX_W-1:0] cpu_idx, dma_idx;
    word_t            cpu_q, dma_q;
    lane_mask_t       lane_coll;
    logic             cpu_wr, dma_wr, cpu_rd, dma_rd;

    dpram_win_dec #(.ADDR_W(ADDR_W), .BASE(BASE_ADDR), .SIZE_BYTES(SIZE_BYTES), .IDX_W(IDX_W))
        u_cpu_dec (.addr(cpu_addr), .hit(cpu_hit), .idx(cpu_idx));
    dpram_win_dec #(.ADDR_W(ADDR_W), .BASE(BASE_ADDR), .SIZE_BYTES(SIZE_BYTES), .IDX_W(IDX_W))
        u_dma_dec (.addr(dma_addr), .hit(dma_hit), .idx(dma_idx));

    always_comb begin
        cpu_wr = cpu_en && cpu_we && cpu_hit;
        dma_wr = dma_en && dma_we && dma_hit;
        cpu_rd = cpu_en && !cpu_we;
        dma_rd = dma_en && !dma_we;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        dpram_lane_bank #(.DEPTH(DEPTH), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .cpu_wr   (cpu_wr && cpu_be[l]),
            .cpu_idx  (cpu_idx),
            .cpu_d    (cpu_wdata[l*LANE_W +: LANE_W]),
            .dma_wr   (dma_wr && dma_be[l]),
            .dma_idx  (dma_idx),
            .dma_d    (dma_wdata[l*LANE_W +: LANE_W]),
            .cpu_q    (cpu_q[l*LANE_W +: LANE_W]),
            .dma_q    (dma_q[l*LANE_W +: LANE_W]),
            .lane_coll(lane_coll[l])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_rdata <= '0;
            dma_rdata <= '0;
            dma_coll  <= 1'b0;
        end else begin
            if (cpu_rd) cpu_rdata <= cpu_hit ? cpu_q : '0;
            if (dma_rd) dma_rdata <= dma_hit ? dma_q : '0;
            dma_coll <= |lane_coll;
        end
    end

    AST_CPU_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_hit) |=> (cpu_rdata == '0)); // R6
    AST_DMA_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd && !dma_hit) |=> (dma_rdata == '0)); // R6
    AST_COLL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_coll |-> $past(cpu_en && cpu_we && dma_en && dma_we && ((cpu_be & dma_be) != 2'b00))); // R5
    AST_CPU_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_en && !cpu_we) |=> $stable(cpu_rdata)); // R9
    AST_DMA_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_en && !dma_we) |=> $stable(dma_rdata)); // R9
endmodule

// File: tb/dpram_cpu_prio_tb.sv
module dpram_cpu_prio_tb_top;
    localparam logic [15:0] BASE  = 16'hF800;
    localparam int          DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_en = 0, cpu_we = 0, dma_en = 0, dma_we = 0;
    logic [1:0]  cpu_be = 0, dma_be = 0;
    logic [15:0] cpu_addr = 0, cpu_wdata = 0, dma_addr = 0, dma_wdata = 0;
    logic [15:0] cpu_rdata, dma_rdata;
    logic        dma_coll;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] model [DEPTH];
    logic [15:0] exp_crd = 0, exp_drd = 0;
    logic        exp_coll = 0;

    always #5 clk = ~clk;

    dpram_cpu_prio dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_be(cpu_be), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .dma_en(dma_en), .dma_we(dma_we), .dma_be(dma_be), .dma_addr(dma_addr),
        .dma_wdata(dma_wdata), .dma_rdata(dma_rdata), .dma_coll(dma_coll)
    );

    function automatic bit in_win(logic [15:0] a);
        return ({1'b0, a} >= {1'b0, BASE}) && ({1'b0, a} < ({1'b0, BASE} + 17'(2*DEPTH)));
    endfunction

    function automatic int widx(logic [15:0] a);
        logic [15:0] off;
        off = a - BASE;
        return int'(off[10:1]);
    endfunction

    function automatic logic [15:0] rand_addr();
        int r;
        r = int'($urandom % 10);
        if (r < 6)      return BASE + 16'(2 * ($urandom % 8)) + 16'($urandom % 2);
        else if (r < 9) return BASE + 16'(2 * ($urandom % DEPTH));
        else            return 16'($urandom % 32'hF800);
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cycle(string tag,
                         logic ce, logic cw, logic [1:0] cbe, logic [15:0] ca, logic [15:0] cd,
                         logic de, logic dw, logic [1:0] dbe, logic [15:0] da, logic [15:0] dd);
        bit ch, dh, same;
        int ci, di;
        logic [1:0] lc, ld;
        cpu_en = ce; cpu_we = cw; cpu_be = cbe; cpu_addr = ca; cpu_wdata = cd;
        dma_en = de; dma_we = dw; dma_be = dbe; dma_addr = da; dma_wdata = dd;
        ch = in_win(ca); dh = in_win(da);
        ci = widx(ca);   di = widx(da);
        same = (ci == di);
        lc = (ce && cw && ch) ? cbe : 2'b00;
        ld = (de && dw && dh) ? dbe : 2'b00;
        if (ce && !cw) exp_crd = ch ? model[ci] : 16'h0;
        if (de && !dw) exp_drd = dh ? model[di] : 16'h0;
        exp_coll = same && ((lc & ld) != 2'b00);
        for (int l = 0; l < 2; l++) begin
            if (ld[l] && !(same && lc[l])) model[di][l*8 +: 8] = dd[l*8 +: 8];
            if (lc[l]) model[ci][l*8 +: 8] = cd[l*8 +: 8];
        end
        @(negedge clk);
        check({tag, " cpu_rdata"}, cpu_rdata, exp_crd);
        check({tag, " dma_rdata"}, dma_rdata, exp_drd);
        check({tag, " dma_coll"}, {15'h0, dma_coll}, {15'h0, exp_coll});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9 reset cpu_rdata", cpu_rdata, 16'h0);
        check("R9 reset dma_rdata", dma_rdata, 16'h0);
        check("R9 reset dma_coll", {15'h0, dma_coll}, 16'h0);

        // R2: fill whole window from CPU, DMA idle (general-purpose storage)
        for (int i = 0; i < DEPTH; i++)
            cycle("R2 fill", 1, 1, 2'b11, BASE + 16'(2*i), 16'(i * 37 + 5), 0, 0, 2'b00, 16'h0, 16'h0);
        cycle("R2 read", 1, 0, 2'b11, BASE + 16'd20, 16'h0, 0, 0, 2'b00, 16'h0, 16'h0);
        cycle("R2 byte write", 1, 1, 2'b10, BASE + 16'd20, 16'hAB00, 0, 0, 2'b00, 16'h0, 16'h0);
        cycle("R2 readback", 1, 0, 2'b11, BASE + 16'd20, 16'h0, 0, 0, 2'b00, 16'h0, 16'h0);

        // R1: window edges
        cycle("R1 top word wr", 1, 1, 2'b11, 16'hFFFE, 16'h5A5A, 0, 0, 2'b00, 16'h0, 16'h0);
        cycle("R1 top word rd", 1, 0, 2'b11, 16'hFFFF, 16'h0, 1, 0, 2'b11, 16'hFFFE, 16'h0);
        cycle("R1 below base rd", 1, 0, 2'b11, 16'hF7FE, 16'h0, 1, 0, 2'b11, BASE, 16'h0);

        // R3 / R5: full collision, then pulse drops
        cycle("R3 collide", 1, 1, 2'b11, BASE + 16'd8, 16'h1111, 1, 1, 2'b11, BASE + 16'd8, 16'h2222);
        cycle("R5 pulse end", 1, 0, 2'b11, BASE + 16'd8, 16'h0, 0, 0, 2'b00, 16'h0, 16'h0);
        cycle("R3 readback", 0, 0, 2'b00, 16'h0, 16'h0, 1, 0, 2'b11, BASE + 16'd8, 16'h0);

        // R4: disjoint lanes, same word
        cycle("R4 split", 1, 1, 2'b01, BASE + 16'd12, 16'h00C3, 1, 1, 2'b10, BASE + 16'd12, 16'h3C00);
        cycle("R4 readback", 1, 0, 2'b11, BASE + 16'd12, 16'h0, 1, 0, 2'b11, BASE + 16'd12, 16'h0);

        // R7: read meets write on the other port
        cycle("R7 cpu rd dma wr", 1, 0, 2'b11, BASE + 16'd30, 16'h0, 1, 1, 2'b11, BASE + 16'd30, 16'hBEEF);
        cycle("R7 dma rd cpu wr", 1, 1, 2'b11, BASE + 16'd30, 16'hCAFE, 1, 0, 2'b11, BASE + 16'd30, 16'h0);
        cycle("R7 readback", 1, 0, 2'b11, BASE + 16'd30, 16'h0, 0, 0, 2'b00, 16'h0, 16'h0);

        // R6: out-of-window write aliasing word 0, out-of-window read
        cycle("R6 alias write", 1, 1, 2'b11, 16'h7800, 16'hDEAD, 1, 1, 2'b11, 16'h7800, 16'hD00D);
        cycle("R6 alias check", 1, 0, 2'b11, BASE, 16'h0, 1, 0, 2'b11, 16'h7800, 16'h0);

        // R8: mixed random traffic on both ports, hot set for collisions
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] ca, da;
            ca = rand_addr();
            da = rand_addr();
            cycle("R8 random", 1'($urandom % 4 != 0), 1'($urandom % 2), 2'($urandom), ca, 16'($urandom),
                  1'($urandom % 4 != 0), 1'($urandom % 2), 2'($urandom), da, 16'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule